// File: doc/BRIEF.md
# Synchronized Event Tally with Coherent Capture

This block counts rising edges of an external signal that has no timing relationship to the internal clock. The external signal never clocks any register. It first passes through a chain of flip-flops that brings it into the internal clock domain. A one-bit history register then compares the newest synchronized sample with the sample from the cycle before. Each low-to-high transition gives a single-cycle increment enable, and a wide binary counter advances only in cycles where that enable is high.

Software or neighbouring logic can read the running total in two ways: from the live count output, or from a capture register. A one-cycle capture strobe copies every bit of the counter, as it stood in that clock cycle, into the capture register. The counter keeps running while this happens, in the same way a stopwatch records lap times without stopping. A valid flag marks the cycle in which a new capture appears. Reliable edge detection needs the external signal to toggle at less than half the internal clock rate.

Top module: `async_event_tally`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count_out`, `snap_out` and `snap_valid` all become 0.
- R2: One low-to-high transition of `event_in` adds exactly 1 to the count, however many cycles the input then stays high.
- R3: When `event_in` goes high before clock edge E1, `count_out` still holds its old value after E1 and E2, and shows the incremented value after E3. This is two synchronizer stages plus one counter register.
- R4: A high-to-low transition, or a level that holds steady, leaves `count_out` unchanged.
- R5: When `snap_req` is high at a clock edge, `snap_out` takes the value that `count_out` showed in the cycle before that edge. The count keeps advancing as usual.
- R6: When `snap_req` and an increment fall on the same edge, the capture holds the pre-increment value and the count still increments.
- R7: `snap_valid` is high for exactly the one cycle after each edge at which `snap_req` was high. At all other times `snap_out` holds its last value.
- R8: Pulses that are two cycles high and two cycles low are all counted, with none lost.
- R9: Reset clears the synchronizer and the edge history to 0. An `event_in` already high when reset ends therefore counts as one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| event_in | input | 1 | Asynchronous external event signal |
| snap_req | input | 1 | Capture strobe, one cycle |
| count_out | output | CNT_W | Live count |
| snap_out | output | CNT_W | Captured count |
| snap_valid | output | 1 | High in the cycle a new capture appears |

## Verification
An increment and a capture can land on the same clock edge. The bench provokes this by raising `event_in` and then asserting `snap_req` two negative edges later, so that the strobe is sampled at the edge where the synchronized rise reaches the counter. A scoreboard entry records the pre-increment total. The monitor compares it with `snap_out` when `snap_valid` rises, and a direct check confirms that the live count still moved up by one.

// File: rtl/evt_tally_pkg.sv
package evt_tally_pkg;

    localparam int TALLY_W_DEF  = 32;
    localparam int SYNC_MIN     = 2;
    localparam int SYNC_DEF     = 2;

    // edge history: newest synchronized sample and the one before it
    typedef struct packed {
        logic cur;
        logic prev;
    } edge_hist_t;

    function automatic logic is_rise(input edge_hist_t h);
        return h.cur & ~h.prev;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int STAGES = evt_tally_pkg::SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES < evt_tally_pkg::SYNC_MIN) begin : g_bad
            initial $error("evt_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], async_in};
        end
    end

    assign sync_out = chain_q[LAST];

endmodule

// File: rtl/evt_rise_det.sv
module evt_rise_det
    import evt_tally_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic rise
);
    edge_hist_t hist;
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_in;
        end
    end

    assign hist.cur  = sync_in;
    assign hist.prev = prev_q;
    assign rise      = is_rise(hist);

    // a rise pulse never lasts two cycles
    assert_one_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int W = evt_tally_pkg::TALLY_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_en,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (inc_en) begin
            count_q <= count_q + ONE;
        end
    end

    assign count = count_q;

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        inc_en |=> count_q == W'($past(count_q) + ONE));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !inc_en |=> $stable(count_q));

endmodule

// File: rtl/evt_snapshot.sv
module evt_snapshot #(
    parameter int W = evt_tally_pkg::TALLY_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic [W-1:0] live,
    output logic [W-1:0] held,
    output logic         fresh
);
    logic [W-1:0] held_q;
    logic         fresh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            fresh_q <= 1'b0;
        end else begin
            fresh_q <= take;
            if (take) begin
                held_q <= live;
            end
        end
    end

    assign held  = held_q;
    assign fresh = fresh_q;

    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        take |=> held_q == $past(live));

    assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(held_q) && !fresh_q);

endmodule

// File: rtl/async_event_tally.sv
module async_event_tally #(
    parameter int CNT_W       = evt_tally_pkg::TALLY_W_DEF,
    parameter int SYNC_STAGES = evt_tally_pkg::SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             event_in,
    input  logic             snap_req,
    output logic [CNT_W-1:0] count_out,
    output logic [CNT_W-1:0] snap_out,
    output logic             snap_valid
);
    logic             ev_sync;
    logic             ev_rise;
    logic [CNT_W-1:0] live_cnt;

    evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (event_in),
        .sync_out (ev_sync)
    );

    evt_rise_det u_rise (
        .clk     (clk),
        .rst     (rst),
        .sync_in (ev_sync),
        .rise    (ev_rise)
    );

    evt_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc_en (ev_rise),
        .count  (live_cnt)
    );

    evt_snapshot #(.W(CNT_W)) u_snap (
        .clk   (clk),
        .rst   (rst),
        .take  (snap_req),
        .live  (live_cnt),
        .held  (snap_out),
        .fresh (snap_valid)
    );

    assign count_out = live_cnt;

    // a capture strobe never disturbs the count beyond a single step
    assert_run_on_R6: assert property (@(posedge clk) disable iff (rst)
        snap_req |=> (count_out == $past(count_out)) ||
                     (count_out == CNT_W'($past(count_out) + CNT_W'(1))));

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> count_out == '0 && snap_out == '0 && !snap_valid);

endmodule

// File: tb/async_event_tally_test.sv
module async_event_tally_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         event_in;
    logic         snap_req;
    logic [W-1:0] count_out;
    logic [W-1:0] snap_out;
    logic         snap_valid;

    int unsigned  n_total = 0;
    int unsigned  n_fail  = 0;
    int unsigned  model   = 0;
    bit           done    = 1'b0;
    logic [W-1:0] exp_q[$];

    async_event_tally #(.CNT_W(W), .SYNC_STAGES(2)) uut (
        .clk        (clk),
        .rst        (rst),
        .event_in   (event_in),
        .snap_req   (snap_req),
        .count_out  (count_out),
        .snap_out   (snap_out),
        .snap_valid (snap_valid)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver: strobe a capture and push the expected captured value
    task automatic request_snap(input logic [W-1:0] expect_val);
        snap_req = 1'b1;
        exp_q.push_back(expect_val);
        @(negedge clk);
        snap_req = 1'b0;
    endtask

    task automatic pulse(input int hi, input int lo);
        event_in = 1'b1;
        wait_n(hi);
        event_in = 1'b0;
        wait_n(lo);
    endtask

    // monitor: compare each published capture with the scoreboard
    always @(negedge clk) begin
        if (!rst && snap_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected valid", snap_out, '0);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                chk(snap_out == e, "R5 capture value", snap_out, e);
            end
        end
    end

    initial begin
        rst = 1'b1; event_in = 1'b0; snap_req = 1'b0;
        wait_n(4);
        chk(count_out == 0, "R1 count", count_out, 0);
        chk(snap_out == 0, "R1 snap", snap_out, 0);
        chk(snap_valid == 0, "R1 valid", W'(snap_valid), 0);
        rst = 1'b0;
        wait_n(4);
        chk(count_out == 0, "R4 idle low", count_out, 0);

        // R3 latency of three edges
        event_in = 1'b1;
        wait_n(1);
        chk(count_out == 0, "R3 after E1", count_out, 0);
        wait_n(1);
        chk(count_out == 0, "R3 after E2", count_out, 0);
        wait_n(1);
        model = 1;
        chk(count_out == W'(model), "R3 after E3", count_out, W'(model));
        // R2 long high level counts once
        wait_n(20);
        chk(count_out == W'(model), "R2 held high", count_out, W'(model));
        // R4 falling edge no count
        event_in = 1'b0;
        wait_n(6);
        chk(count_out == W'(model), "R4 falling", count_out, W'(model));

        // R5 idle capture, R7 single-cycle valid and hold
        request_snap(W'(model));
        chk(snap_valid == 1, "R7 valid high", W'(snap_valid), 1);
        chk(count_out == W'(model), "R5 count unaffected", count_out, W'(model));
        wait_n(1);
        chk(snap_valid == 0, "R7 valid drops", W'(snap_valid), 0);
        chk(snap_out == W'(model), "R7 snap holds", snap_out, W'(model));

        // R8 burst at quarter rate
        for (int k = 0; k < 10; k++) pulse(2, 2);
        wait_n(4);
        model += 10;
        chk(count_out == W'(model), "R8 burst", count_out, W'(model));

        // R5 capture right after an increment, count running
        event_in = 1'b1;
        wait_n(3);
        model++;
        request_snap(W'(model));
        event_in = 1'b0;
        wait_n(3);

        // R6 strobe on the same edge as the increment
        event_in = 1'b1;
        wait_n(2);
        request_snap(W'(model));
        model++;
        chk(count_out == W'(model), "R6 count still steps", count_out, W'(model));
        chk(snap_valid == 1, "R6 valid", W'(snap_valid), 1);
        event_in = 1'b0;
        wait_n(4);
        chk(snap_out == W'(model - 1), "R6 pre-increment held", snap_out, W'(model - 1));

        // R9 input high across reset counts once
        rst = 1'b1; event_in = 1'b1;
        wait_n(3);
        chk(count_out == 0, "R1 reset again", count_out, 0);
        rst = 1'b0;
        wait_n(6);
        model = 1;
        chk(count_out == W'(model), "R9 high at release", count_out, W'(model));
        event_in = 1'b0;
        wait_n(4);

        chk(exp_q.size() == 0, "R7 all captures seen", W'(exp_q.size()), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule